// File: doc/BRIEF.md
# Receive I/Q Imbalance Corrector

This block removes gain and phase mismatch between the in-phase and quadrature branches of a receive path in a single static pass. Every accepted complex sample is multiplied by a fixed lower-triangular correction matrix. The in-phase value is rescaled by (1 + A/64). The quadrature value keeps unity gain and gains a fraction B/64 of the in-phase value. A is the gain term and B is the skew term. Both are signed two's-complement coefficients held in two writable registers. The block never estimates or adapts them.

Samples enter as an I/Q pair qualified by a valid strobe and leave three clock cycles later with their own valid strobe. Each sample captures the coefficient pair at the moment it is accepted and carries that pair down the pipeline. A register write therefore never alters a sample already in flight. Results that exceed the output width are clamped to the largest or smallest representable value.

There is no control sequencer. The datapath is a straight three-register pipeline: capture, multiply, then add and clamp.

Top module: `iq_imbal_corr`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0, `out_i` = 0, `out_q` = 0, and both coefficients return to 0.
- R2: `out_valid` equals `in_valid` as it was three clock edges earlier. The latency is fixed and the same for every sample.
- R3: For a sample with in-phase value I, `out_i` = I + floor(I·A/64), where A is the signed gain coefficient in force when the sample was accepted.
- R4: `out_q` = Q + floor(I·B/64), where B is the signed skew coefficient in force when the sample was accepted. Q itself is never scaled.
- R5: With A = 0 and B = 0, `out_i` and `out_q` equal the input I and Q of the same sample.
- R6: A result above 2^(DATA_W-1)-1 leaves as 2^(DATA_W-1)-1, and a result below -2^(DATA_W-1) leaves as -2^(DATA_W-1). Results never wrap.
- R7: A write with `cfg_we` = 1 and `cfg_addr` = 0 loads A from `cfg_wdata`, and a write to `cfg_addr` = 1 loads B. The data is read as signed two's complement. A write to any other address changes neither coefficient.
- R8: A sample accepted in the same cycle as a coefficient write uses the old coefficient, and the next accepted sample uses the new one. A write made while samples are in the pipeline does not change their results.
- R9: In a cycle where `out_valid` is 0, `out_i` and `out_q` keep the values of the last valid result. Input data offered with `in_valid` = 0 has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | ADDR_W | Coefficient select: 0 selects the gain coefficient A, 1 selects the skew coefficient B |
| cfg_wdata | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DATA_W | Signed in-phase input |
| in_q | input | DATA_W | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DATA_W | Corrected in-phase output |
| out_q | output | DATA_W | Corrected quadrature output |

## Verification
A coefficient write and a sample acceptance can fall in the same clock cycle. This is the collision that decides which coefficient a sample uses. The bench drives a write together with a valid sample, and also issues writes while earlier samples are still in the pipeline. A behavioural model compares the outputs every cycle, with coefficients that update only after the model has evaluated the sample of that edge. A sample paired with a write must therefore show the old coefficient, and the next sample must show the new one.

// File: rtl/iqc_pkg.sv
package iqc_pkg;
    // register selects; software relies on these two values
    localparam int unsigned SEL_GAIN = 0;
    localparam int unsigned SEL_SKEW = 1;
    localparam int unsigned NUM_COEF = 2;
    // 1/64 scaling of the correction terms
    localparam int unsigned FRAC_SHIFT = 6;
    // register stages from input to output
    localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/iqc_coef_bank.sv
module iqc_coef_bank #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [COEF_W-1:0]        wdata,
    output logic signed [COEF_W-1:0] gain,
    output logic signed [COEF_W-1:0] skew
);
    import iqc_pkg::*;

    logic signed [COEF_W-1:0] coef_q [NUM_COEF];

    for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst) begin
                coef_q[k] <= '0;
            end else if (we && (addr == ADDR_W'(k))) begin
                coef_q[k] <= wdata;
            end
        end

        // R7
        foreign_addr_keeps_coef_chk: assert property (@(posedge clk) disable iff (rst)
            (we && (addr != ADDR_W'(k))) |=> $stable(coef_q[k]));
    end

    assign gain = coef_q[SEL_GAIN];
    assign skew = coef_q[SEL_SKEW];
endmodule

// File: rtl/iqc_product_stage.sv
module iqc_product_stage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned COEF_W = 16,
    localparam int unsigned PW = DATA_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_in,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    input  logic signed [COEF_W-1:0] gain_in,
    input  logic signed [COEF_W-1:0] skew_in,
    output logic                     v_out,
    output logic signed [DATA_W-1:0] i_out,
    output logic signed [DATA_W-1:0] q_out,
    output logic signed [PW-1:0]     prod_gain,
    output logic signed [PW-1:0]     prod_skew,
    output logic                     coefs_zero
);
    // capture register: the sample and the coefficients in force when it is accepted
    logic                     cap_v;
    logic signed [DATA_W-1:0] cap_i, cap_q;
    logic signed [COEF_W-1:0] cap_gain, cap_skew;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_v    <= 1'b0;
            cap_i    <= '0;
            cap_q    <= '0;
            cap_gain <= '0;
            cap_skew <= '0;
        end else begin
            cap_v <= v_in;
            if (v_in) begin
                cap_i    <= i_in;
                cap_q    <= q_in;
                cap_gain <= gain_in;
                cap_skew <= skew_in;
            end
        end
    end

    logic signed [PW-1:0] i_ext, g_ext, s_ext;
    assign i_ext = PW'(cap_i);
    assign g_ext = PW'(cap_gain);
    assign s_ext = PW'(cap_skew);

    // multiply register
    always_ff @(posedge clk) begin
        if (rst) begin
            v_out      <= 1'b0;
            i_out      <= '0;
            q_out      <= '0;
            prod_gain  <= '0;
            prod_skew  <= '0;
            coefs_zero <= 1'b1;
        end else begin
            v_out <= cap_v;
            if (cap_v) begin
                i_out      <= cap_i;
                q_out      <= cap_q;
                prod_gain  <= i_ext * g_ext;
                prod_skew  <= i_ext * s_ext;
                coefs_zero <= (cap_gain == '0) && (cap_skew == '0);
            end
        end
    end
endmodule

// File: rtl/iqc_sat_stage.sv
module iqc_sat_stage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned COEF_W = 16,
    localparam int unsigned PW = DATA_W + COEF_W,
    localparam int unsigned SW = PW + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_in,
    input  logic signed [DATA_W-1:0] i_in,
    input  logic signed [DATA_W-1:0] q_in,
    input  logic signed [PW-1:0]     prod_gain,
    input  logic signed [PW-1:0]     prod_skew,
    input  logic                     coefs_zero,
    output logic                     v_out,
    output logic signed [DATA_W-1:0] i_out,
    output logic signed [DATA_W-1:0] q_out
);
    import iqc_pkg::*;

    localparam logic signed [SW-1:0] HI = SW'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [SW-1:0] sum_i, sum_q;
    logic signed [DATA_W-1:0] clip_i, clip_q;

    // floor division by 64 via arithmetic shift of the product
    assign sum_i = SW'(i_in) + SW'(prod_gain >>> FRAC_SHIFT);
    assign sum_q = SW'(q_in) + SW'(prod_skew >>> FRAC_SHIFT);

    always_comb begin
        if (sum_i > HI)      clip_i = HI[DATA_W-1:0];
        else if (sum_i < LO) clip_i = LO[DATA_W-1:0];
        else                 clip_i = sum_i[DATA_W-1:0];
        if (sum_q > HI)      clip_q = HI[DATA_W-1:0];
        else if (sum_q < LO) clip_q = LO[DATA_W-1:0];
        else                 clip_q = sum_q[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            i_out <= '0;
            q_out <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                i_out <= clip_i;
                q_out <= clip_q;
            end
        end
    end

    // R5
    unity_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (v_in && coefs_zero) |=> ((i_out == $past(i_in)) && (q_out == $past(q_in))));
endmodule

// File: rtl/iq_imbal_corr.sv
module iq_imbal_corr #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_i,
    output logic [DATA_W-1:0] out_q
);
    import iqc_pkg::*;

    localparam int unsigned PW = DATA_W + COEF_W;

    logic signed [COEF_W-1:0] gain, skew;

    iqc_coef_bank #(.ADDR_W(ADDR_W), .COEF_W(COEF_W)) i_coef (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .gain(gain), .skew(skew)
    );

    logic                     m_v, m_zero;
    logic signed [DATA_W-1:0] m_i, m_q;
    logic signed [PW-1:0]     m_pg, m_ps;

    iqc_product_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_prod (
        .clk(clk), .rst(rst),
        .v_in(in_valid), .i_in(in_i), .q_in(in_q),
        .gain_in(gain), .skew_in(skew),
        .v_out(m_v), .i_out(m_i), .q_out(m_q),
        .prod_gain(m_pg), .prod_skew(m_ps), .coefs_zero(m_zero)
    );

    logic signed [DATA_W-1:0] o_i, o_q;

    iqc_sat_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_sat (
        .clk(clk), .rst(rst),
        .v_in(m_v), .i_in(m_i), .q_in(m_q),
        .prod_gain(m_pg), .prod_skew(m_ps), .coefs_zero(m_zero),
        .v_out(out_valid), .i_out(o_i), .q_out(o_q)
    );

    assign out_i = o_i;
    assign out_q = o_q;

    // edges since reset, saturating at the pipeline depth (for the latency check)
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                   warm <= '0;
        else if (warm != 2'(PIPE_DEPTH)) warm <= warm + 2'd1;
    end

    // R1
    reset_clears_out_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_i == '0) && (out_q == '0)));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'(PIPE_DEPTH)) |-> (out_valid == $past(in_valid, 3)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/test_iq_imbal_corr.sv
module test_iq_imbal_corr;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_i = '0, in_q = '0;
    logic          out_valid;
    logic [DW-1:0] out_i, out_q;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit started = 0, done = 0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    iq_imbal_corr #(.DATA_W(DW), .COEF_W(CW), .ADDR_W(AW)) i_iq_imbal_corr (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // behavioural reference model
    longint m_gain = 0, m_skew = 0;
    bit     e_v [3];
    longint e_i [3];
    longint e_q [3];
    longint exp_oi = 0, exp_oq = 0;

    function automatic longint clampv(longint x);
        longint hi = (64'sd1 <<< (DW - 1)) - 1;
        longint lo = -(64'sd1 <<< (DW - 1));
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) begin e_v[k] = 0; e_i[k] = 0; e_q[k] = 0; end
            exp_oi = 0; exp_oq = 0; m_gain = 0; m_skew = 0;
            started = 1;
        end else begin
            longint vi, vq;
            vi = longint'($signed(in_i));
            vq = longint'($signed(in_q));
            for (int k = 2; k > 0; k--) begin
                e_v[k] = e_v[k-1]; e_i[k] = e_i[k-1]; e_q[k] = e_q[k-1];
            end
            e_v[0] = in_valid;
            e_i[0] = clampv(vi + ((vi * m_gain) >>> 6));
            e_q[0] = clampv(vq + ((vi * m_skew) >>> 6));
            if (e_v[2]) begin exp_oi = e_i[2]; exp_oq = e_q[2]; end
            if (cfg_we && cfg_addr == 0) m_gain = longint'($signed(cfg_wdata));
            if (cfg_we && cfg_addr == 1) m_skew = longint'($signed(cfg_wdata));
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (out_valid !== e_v[2]) begin
                failures++;
                $display("FAIL R2 (%s) out_valid=%0b exp=%0b", cur_req, out_valid, e_v[2]);
            end
            checks++;
            if (longint'($signed(out_i)) != exp_oi || $isunknown(out_i)) begin
                failures++;
                $display("FAIL %s out_i=%0d exp=%0d", cur_req, $signed(out_i), exp_oi);
            end
            checks++;
            if (longint'($signed(out_q)) != exp_oq || $isunknown(out_q)) begin
                failures++;
                $display("FAIL %s out_q=%0d exp=%0d", cur_req, $signed(out_q), exp_oq);
            end
        end
    end

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic cyc(bit we, int addr, int data, bit v, int i, int q);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = AW'(addr);
        cfg_wdata = CW'(data);
        in_valid  = v;
        in_i      = DW'(i);
        in_q      = DW'(q);
    endtask

    task automatic rand_samples(int n, bit gaps);
        for (int k = 0; k < n; k++) begin
            int unsigned r = rnd();
            cyc(0, 0, 0, gaps ? r[3] | r[7] : 1'b1, int'(rnd() & 16'hFFFF), int'(rnd() & 16'hFFFF));
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst = 0;
        idle(4);

        cur_req = "R5";
        rand_samples(24, 1);
        idle(4);

        cur_req = "R3 R4";
        cyc(1, 0, 32, 0, 0, 0);
        cyc(1, 1, -16, 0, 0, 0);
        rand_samples(30, 1);
        cyc(1, 0, -100, 0, 0, 0);
        cyc(1, 1, 100, 0, 0, 0);
        rand_samples(30, 0);
        cyc(1, 0, -64, 1, 777, -5);
        cyc(0, 0, 0, 1, -777, 5);
        idle(4);

        cur_req = "R6";
        cyc(1, 0, 2000, 0, 0, 0);
        cyc(1, 1, 4000, 0, 0, 0);
        cyc(0, 0, 0, 1, 30000, 30000);
        cyc(0, 0, 0, 1, -30000, -30000);
        cyc(0, 0, 0, 1, 0, 32767);
        cyc(1, 0, -32768, 1, 32767, 0);
        cyc(1, 1, -32768, 1, -32768, 0);
        cyc(0, 0, 0, 1, -32768, -32768);
        idle(4);

        cur_req = "R7";
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 1, 64, 0, 0, 0);
        cyc(1, 5, 1234, 0, 0, 0);
        cyc(1, 2, -7, 0, 0, 0);
        cyc(1, 15, 999, 1, 640, 10);
        rand_samples(10, 0);
        idle(4);

        cur_req = "R8";
        cyc(1, 0, 64, 1, 1000, 20);
        cyc(0, 0, 0, 1, 1000, 20);
        cyc(1, 1, -64, 1, 1000, 20);
        cyc(1, 0, 0, 1, 2000, 30);
        cyc(1, 1, 0, 1, 2000, 30);
        cyc(0, 0, 0, 1, 2000, 30);
        for (int k = 0; k < 20; k++)
            cyc(1, int'(rnd() & 1), int'(rnd() & 16'hFFFF), 1, int'(rnd() & 16'hFFFF), int'(rnd() & 16'hFFFF));
        idle(4);

        cur_req = "R9";
        cyc(1, 0, 50, 1, 400, 400);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, int'(rnd() & 16'hFFFF), int'(rnd() & 16'hFFFF));
        rand_samples(30, 1);
        idle(4);

        cur_req = "R1";
        rst = 1;
        idle(3);
        rst = 0;
        cyc(0, 0, 0, 1, 1234, -1234);
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule